// File: doc/BRIEF.md
# Exception Entry Sequencer

This block takes over the processor when an exception is raised and walks it through a fixed entry sequence. Five request lines can be pending at once: bus error, address error, trace, external interrupt, and trap-class instruction. The last line also covers illegal and privileged opcodes. The sequencer accepts one request at a time and picks the winner by a fixed priority. It then runs its steps in a set order:

1. Take a private copy of the status register.
2. Resolve the vector number.
3. Push the return program counter and the saved status onto the chosen stack.
4. Read the vector from the vector base register plus four times the vector number.

When the vector read finishes, the block presents the fetched word as the new program counter for one cycle. In the same cycle it presents the updated status register and the new stack pointer value, together with the stack it applies to. Memory traffic uses one request/acknowledge port that carries both the frame writes and the vector read.

The stack choice depends on the master bit and on the kind of exception. A task-related exception uses the master stack when the master bit is set in the status copy, and the interrupt stack otherwise. An interrupt always switches to the interrupt stack and clears the master bit.

Top module: `exc_entry_seq`

## Requirements
- R1: When several requests are sampled together, the one served is the first present in this order: bus error, address error, trace, interrupt, trap-class.
- R2: The vector number is 2 for bus error, 3 for address error and 9 for trace. Interrupts take `irq_vec` and trap-class requests take `trap_vec`, both read in the vector step.
- R3: Bus error, address error, trace and trap-class use the master stack (`sp_sel`=1, base `msp_in`) when bit 12 (master) of the status copy is 1, and the interrupt stack (`sp_sel`=0, base `isp_in`) otherwise. An interrupt always uses the interrupt stack.
- R4: `sr_out` equals the status copy with bit 13 (supervisor) set. Bit 12 is also cleared when the request was an interrupt. All other bits are unchanged.
- R5: The frame is two 32-bit writes going downward. The first writes the return PC at base−4. The second writes the zero-extended status copy at base−8. `sp_out` is base−8.
- R6: After both frame writes, exactly one read is issued, at `vbr` + 4 × vector number. This covers offsets 0 to 1020.
- R7: `new_pc_valid` pulses for one cycle after the read is acknowledged. In that cycle `new_pc` equals the read data and `sr_out`, `sp_out` and `sp_sel` are valid.
- R8: `busy` rises on the edge that samples a request while idle and stays high through the `new_pc_valid` cycle. It falls on the next edge. Requests seen while busy are dropped and start no later sequence.
- R9: A memory request stays high with a stable address and direction until the edge on which `mem_ack` is seen.
- R10: The status copy is taken on the edge after acceptance, and no memory request is made in the first busy cycle. Later changes on `sr_in` do not affect the saved frame, `sr_out` or the stack choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_berr | input | 1 | Bus error request |
| req_aerr | input | 1 | Address error request |
| req_trace | input | 1 | Trace request |
| req_irq | input | 1 | Interrupt request |
| req_trap | input | 1 | Trap-class instruction request |
| irq_vec | input | 8 | Vector number for an interrupt |
| trap_vec | input | 8 | Vector number for a trap-class request |
| sr_in | input | 16 | Live status register |
| pc_in | input | 32 | Return program counter |
| vbr | input | 32 | Vector base register |
| msp_in | input | 32 | Master stack pointer |
| isp_in | input | 32 | Interrupt stack pointer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| busy | output | 1 | Entry sequence in progress |
| new_pc_valid | output | 1 | One-cycle strobe: new PC, SR and SP valid |
| new_pc | output | 32 | Fetched handler address |
| sr_out | output | 16 | Updated status register |
| sp_out | output | 32 | Stack pointer after the frame push |
| sp_sel | output | 1 | 1 = master stack, 0 = interrupt stack |

## Verification
The hardest case to reach is proving that the status register was copied at the snapshot step and not read later. The bench inverts `sr_in` on the cycle right after the copy and then checks the pushed status word, `sr_out` and the stack choice against the original value. A second hard case is a request that arrives in the middle of a sequence. The bench raises a bus error while a trap entry is waiting on a slowed acknowledge. It then checks that the trap's vector is still served and that no memory traffic or `busy` follows.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int AW        = 32,
  parameter int SRW       = 16,
  parameter int VW        = 8,
  parameter int S_BIT     = 13,
  parameter int M_BIT     = 12,
  parameter int VEC_BERR  = 2,
  parameter int VEC_AERR  = 3,
  parameter int VEC_TRACE = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_berr,
  input  logic           req_aerr,
  input  logic           req_trace,
  input  logic           req_irq,
  input  logic           req_trap,
  input  logic [VW-1:0]  irq_vec,
  input  logic [VW-1:0]  trap_vec,
  input  logic [SRW-1:0] sr_in,
  input  logic [AW-1:0]  pc_in,
  input  logic [AW-1:0]  vbr,
  input  logic [AW-1:0]  msp_in,
  input  logic [AW-1:0]  isp_in,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [AW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic [AW-1:0]  mem_rdata,
  output logic           busy,
  output logic           new_pc_valid,
  output logic [AW-1:0]  new_pc,
  output logic [SRW-1:0] sr_out,
  output logic [AW-1:0]  sp_out,
  output logic           sp_sel
);

  localparam int WB = AW / 8 / 2 * 2;
  localparam logic [AW-1:0] WORD = AW'(AW / 8);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SNAP, ST_VEC, ST_WPC, ST_WSR, ST_RD, ST_DONE
  } state_t;

  typedef enum logic [2:0] {
    K_BERR, K_AERR, K_TRACE, K_IRQ, K_TRAP
  } kind_t;

  state_t         state;
  kind_t          kind_q, kind_d;
  logic [SRW-1:0] sr_q;
  logic [AW-1:0]  pc_q, base_q, npc_q;
  logic [VW-1:0]  vec_q;
  logic           sel_q;

  wire any_req = req_berr | req_aerr | req_trace | req_irq | req_trap;
  wire is_irq  = (kind_q == K_IRQ);
  wire use_msp = !is_irq && sr_q[M_BIT];

  always_comb begin
    if (req_berr)       kind_d = K_BERR;
    else if (req_aerr)  kind_d = K_AERR;
    else if (req_trace) kind_d = K_TRACE;
    else if (req_irq)   kind_d = K_IRQ;
    else                kind_d = K_TRAP;
  end

  logic [VW-1:0] vec_d;
  always_comb begin
    unique case (kind_q)
      K_BERR:  vec_d = VW'(VEC_BERR);
      K_AERR:  vec_d = VW'(VEC_AERR);
      K_TRACE: vec_d = VW'(VEC_TRACE);
      K_IRQ:   vec_d = irq_vec;
      default: vec_d = trap_vec;
    endcase
  end

  wire [AW-1:0] vec_off  = {{(AW-VW-2){1'b0}}, vec_q, 2'b00};
  wire [AW-1:0] vec_addr = vbr + vec_off;
  wire [AW-1:0] frame_pc = base_q - WORD;
  wire [AW-1:0] frame_sr = base_q - 2 * WORD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      kind_q <= K_TRAP;
      sr_q   <= '0;
      pc_q   <= '0;
      base_q <= '0;
      npc_q  <= '0;
      vec_q  <= '0;
      sel_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (any_req) begin
          kind_q <= kind_d;
          state  <= ST_SNAP;
        end
        ST_SNAP: begin
          sr_q  <= sr_in;
          pc_q  <= pc_in;
          state <= ST_VEC;
        end
        ST_VEC: begin
          vec_q  <= vec_d;
          sel_q  <= use_msp;
          base_q <= use_msp ? msp_in : isp_in;
          state  <= ST_WPC;
        end
        ST_WPC: if (mem_ack) state <= ST_WSR;
        ST_WSR: if (mem_ack) state <= ST_RD;
        ST_RD: if (mem_ack) begin
          npc_q <= mem_rdata;
          state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = (state == ST_WPC) || (state == ST_WSR) || (state == ST_RD);
  assign mem_we    = (state == ST_WPC) || (state == ST_WSR);
  assign mem_addr  = (state == ST_WPC) ? frame_pc :
                     (state == ST_WSR) ? frame_sr : vec_addr;
  assign mem_wdata = (state == ST_WPC) ? pc_q : {{(AW-SRW){1'b0}}, sr_q};

  assign busy         = (state != ST_IDLE);
  assign new_pc_valid = (state == ST_DONE);
  assign new_pc       = npc_q;
  assign sp_out       = frame_sr;
  assign sp_sel       = sel_q;

  always_comb begin
    sr_out        = sr_q;
    sr_out[S_BIT] = 1'b1;
    if (is_irq) sr_out[M_BIT] = 1'b0;
  end

  wire unused_ok = &{1'b0, WB[0]};

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int AW    = 32,
  parameter int SRW   = 16,
  parameter int S_BIT = 13
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           mem_req,
  input logic           mem_we,
  input logic           mem_ack,
  input logic [AW-1:0]  mem_addr,
  input logic [AW-1:0]  vbr,
  input logic           new_pc_valid,
  input logic [SRW-1:0] sr_out
);

  p_busy_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
    new_pc_valid |-> busy);

  p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    new_pc_valid |=> !busy);

  p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_no_mem_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !mem_req);

  p_super_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    new_pc_valid |-> sr_out[S_BIT]);

  p_vec_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> mem_addr[1:0] == vbr[1:0]);

  p_quiet_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    new_pc_valid |-> !mem_req);

endmodule

bind exc_entry_seq exc_entry_seq_chk #(.AW(AW), .SRW(SRW), .S_BIT(S_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .vbr(vbr),
  .new_pc_valid(new_pc_valid), .sr_out(sr_out)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  logic clk = 0, rst_n = 0;
  logic req_berr = 0, req_aerr = 0, req_trace = 0, req_irq = 0, req_trap = 0;
  logic [7:0]  irq_vec = 8'h45, trap_vec = 8'h21;
  logic [15:0] sr_in = 0;
  logic [31:0] pc_in = 32'h0000_2468, vbr = 32'h0000_0400;
  logic [31:0] msp_in = 32'h0000_8000, isp_in = 32'h0000_4000;
  logic mem_req, mem_we, mem_ack = 0, busy, new_pc_valid, sp_sel;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0, new_pc, sp_out;
  logic [15:0] sr_out;

  int total = 0, bad = 0, lat = 0, wcnt = 0, nt = 0;
  logic [31:0] ta [8];
  logic [31:0] td [8];
  logic        tw [8];

  always #5 clk = ~clk;

  exc_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_berr(req_berr), .req_aerr(req_aerr),
    .req_trace(req_trace), .req_irq(req_irq), .req_trap(req_trap),
    .irq_vec(irq_vec), .trap_vec(trap_vec), .sr_in(sr_in), .pc_in(pc_in),
    .vbr(vbr), .msp_in(msp_in), .isp_in(isp_in), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy),
    .new_pc_valid(new_pc_valid), .new_pc(new_pc), .sr_out(sr_out),
    .sp_out(sp_out), .sp_sel(sp_sel));

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack = 1;
        if (!mem_we) mem_rdata = mem_addr ^ 32'h5A5A_0000;
        if (nt < 8) begin
          ta[nt] = mem_addr; td[nt] = mem_wdata; tw[nt] = mem_we;
        end
        nt++;
      end else wcnt++;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // row: {berr,aerr,trace,irq,trap}[29:25], sr[24:9], vec[8:1], use_msp[0]
  localparam logic [29:0] TBL [8] = '{
    {5'b00001, 16'h1000, 8'h21, 1'b1},
    {5'b00001, 16'h0000, 8'h21, 1'b0},
    {5'b00010, 16'h1700, 8'h45, 1'b0},
    {5'b00011, 16'h1000, 8'h45, 1'b0},
    {5'b00110, 16'h1004, 8'h09, 1'b1},
    {5'b01100, 16'h0000, 8'h03, 1'b0},
    {5'b11111, 16'h1001, 8'h02, 1'b1},
    {5'b01000, 16'h2000, 8'h03, 1'b0}
  };

  task automatic run_exc(logic [4:0] reqs, logic [15:0] sr, logic [7:0] ev, logic em,
                         logic ignore_test);
    logic [31:0] base, vaddr;
    logic [15:0] esr;
    int guard;
    nt = 0;
    @(negedge clk);
    {req_berr, req_aerr, req_trace, req_irq, req_trap} = reqs;
    sr_in = sr;
    @(negedge clk);
    {req_berr, req_aerr, req_trace, req_irq, req_trap} = 5'b0;
    check("R8 busy after accept", 32'(busy), 32'd1);
    @(negedge clk);
    sr_in = ~sr;
    if (ignore_test) begin
      @(negedge clk);
      req_berr = 1;
      @(negedge clk);
      @(negedge clk);
      req_berr = 0;
    end
    guard = 0;
    while (!new_pc_valid && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    base  = em ? msp_in : isp_in;
    vaddr = vbr + {22'b0, ev, 2'b00};
    esr   = sr | 16'h2000;
    if (reqs[4:1] == 4'b0001) esr[12] = 1'b0;
    check("R7 strobe seen", 32'(new_pc_valid), 32'd1);
    check("R5 txn count", 32'(nt), 32'd3);
    check("R5 pc write addr", ta[0], base - 4);
    check("R5 pc write data", td[0], pc_in);
    check("R5 pc write dir", 32'(tw[0]), 32'd1);
    check("R10 sr write addr", ta[1], base - 8);
    check("R10 saved sr", td[1], {16'h0, sr});
    check("R6 vector read addr", ta[2], vaddr);
    check("R6 vector read dir", 32'(tw[2]), 32'd0);
    check("R1 R2 vector", (ta[2] - vbr) >> 2, 32'(ev));
    check("R7 new pc", new_pc, vaddr ^ 32'h5A5A_0000);
    check("R4 sr out", 32'(sr_out), 32'(esr));
    check("R3 sp sel", 32'(sp_sel), 32'(em));
    check("R5 sp out", sp_out, base - 8);
    @(negedge clk);
    check("R8 busy falls", 32'(busy), 32'd0);
    check("R7 strobe one cycle", 32'(new_pc_valid), 32'd0);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset busy", 32'(busy), 32'd0);
    check("R9 reset mem_req", 32'(mem_req), 32'd0);
    check("R7 reset strobe", 32'(new_pc_valid), 32'd0);
    rst_n = 1;

    for (int i = 0; i < 8; i++) begin
      lat = i % 3;
      run_exc(TBL[i][29:25], TBL[i][24:9], TBL[i][8:1], TBL[i][0], 1'b0);
    end

    // R6: largest vector offset 1020
    trap_vec = 8'hFF; vbr = 32'h0001_0000; lat = 1;
    run_exc(5'b00001, 16'h0000, 8'hFF, 1'b0, 1'b0);

    // R8: bus error raised mid-sequence is dropped; R9 with slow ack
    trap_vec = 8'h30; lat = 4;
    run_exc(5'b00001, 16'h1000, 8'h30, 1'b1, 1'b1);
    nt = 0;
    repeat (10) @(negedge clk);
    check("R8 ignored req no busy", 32'(busy), 32'd0);
    check("R8 ignored req no traffic", 32'(nt), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule